// File: doc/BRIEF.md
# Masked packed unsigned-integer to double-precision converter

This block turns a vector of up to eight 32-bit unsigned integers into IEEE-754 binary64 values, one 64-bit result lane per integer, and assembles a 512-bit destination word. Every 32-bit unsigned value fits in the 53-bit significand, so the conversion is always exact. It raises no floating-point flags and has no rounding control.

A two-bit length code picks 2, 4 or 8 active lanes. Each active lane is either written with its converted value or masked. When it is masked, it either keeps the old destination lane or is cleared. A broadcast flag makes every lane convert element 0. All bits above the active length are cleared. A 4-bit reserved field must read all ones. Any other value marks the operation illegal, and the old destination passes through unchanged. The result is registered and appears one clock after the inputs.

Top module: `u2d_vec_convert`

## Requirements
- R1: Length code `vlen_sel` 2'b00, 2'b01 and 2'b10 gives 2, 4 and 8 active lanes. Active output lane j (bits 64j+63:64j) is derived from source element j (bits 32j+31:32j).
- R2: The conversion is exact. An input of 0 gives 64'h0. Any other input gives sign 0, exponent field 1023 plus the bit index of its leading one, and the bits below the leading one left-aligned into the 52-bit fraction with zero fill.
- R3: When `mask_on` is 0, every active lane is written with its converted value. When `mask_on` is 1, lane j is written only if `lane_mask[j]` is 1.
- R4: A masked-off active lane with `zero_mode` 0 (merge) keeps the value of the same lane of `dst_old`.
- R5: A masked-off active lane with `zero_mode` 1 (zeroing) is all zeros.
- R6: With `bcast` 1, every active lane converts `src_vec[31:0]`.
- R7: Every destination bit at or above 128, 256 or 512 (the active length) is 0, whatever the mask and `dst_old`.
- R8: If `rsvd_field` is not 4'b1111, or `vlen_sel` is 2'b11, the operation is illegal. Then `illegal` is 1 and `dst_new` equals `dst_old`. Otherwise `illegal` is 0.
- R9: `dst_new` and `illegal` are registered and reflect the inputs of the previous clock edge. A synchronous active-high `rst` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_vec | input | 256 | Packed 32-bit unsigned source elements |
| dst_old | input | 512 | Previous destination value |
| lane_mask | input | 8 | Per-lane write enables |
| mask_on | input | 1 | 1 applies lane_mask, 0 writes all active lanes |
| zero_mode | input | 1 | 1 clears masked lanes, 0 keeps dst_old lanes |
| bcast | input | 1 | Use element 0 for every lane |
| vlen_sel | input | 2 | Active length code |
| rsvd_field | input | 4 | Reserved encoding field, must be 4'b1111 |
| dst_new | output | 512 | Registered new destination |
| illegal | output | 1 | Registered illegal-encoding flag |

## Verification
The bench builds the block with its default parameters: eight 32-bit lanes into 64-bit results. This lets all three length codes and the full 256 mask patterns be swept in both masking modes. The conversion table reaches every leading-one position that matters, including 0, 1, 2^31 and 2^32-1. Expected words come from a model that goes through the simulator's own real-number conversion rather than bit manipulation.

// File: rtl/u2d_pkg.sv
package u2d_pkg;
  localparam int SRC_W  = 32;
  localparam int DST_W  = 64;
  localparam int EXP_W  = 11;
  localparam int MANT_W = 52;
  localparam int BIAS   = 1023;
  localparam logic [3:0] RSVD_OK = 4'b1111;

  typedef enum logic [1:0] {
    VL_128 = 2'b00,
    VL_256 = 2'b01,
    VL_512 = 2'b10,
    VL_BAD = 2'b11
  } vlen_e;
endpackage

// File: rtl/u2d_lead_one.sv
module u2d_lead_one #(
  parameter int W   = 32,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (vec[b]) begin
        pos   = PW'(b);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/u2d_lane_cvt.sv
module u2d_lane_cvt #(
  parameter int SRC_W  = 32,
  parameter int EXP_W  = 11,
  parameter int MANT_W = 52,
  parameter int BIAS   = 1023,
  localparam int DST_W = 1 + EXP_W + MANT_W,
  localparam int PW    = $clog2(SRC_W),
  localparam int SH_W  = PW + 1
) (
  input  logic [SRC_W-1:0] val,
  output logic [DST_W-1:0] res
);
  logic [PW-1:0]    msb;
  logic             nz;
  logic [SH_W-1:0]  sh;
  logic [SRC_W-1:0] frac;
  logic [EXP_W-1:0] expo;

  u2d_lead_one #(.W(SRC_W)) lod_i (.vec(val), .pos(msb), .found(nz));

  always_comb begin
    sh   = SH_W'(SRC_W) - SH_W'(msb);
    frac = val << sh;
    expo = EXP_W'(BIAS) + EXP_W'(msb);
    if (nz) res = {1'b0, expo, frac, {(MANT_W-SRC_W){1'b0}}};
    else    res = '0;
  end
endmodule

// File: rtl/u2d_vec_convert.sv
module u2d_vec_convert
  import u2d_pkg::*;
#(
  parameter int LANES = 8,
  localparam int SRC_BITS = LANES * SRC_W,
  localparam int DST_BITS = LANES * DST_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SRC_BITS-1:0] src_vec,
  input  logic [DST_BITS-1:0] dst_old,
  input  logic [LANES-1:0]    lane_mask,
  input  logic                mask_on,
  input  logic                zero_mode,
  input  logic                bcast,
  input  logic [1:0]          vlen_sel,
  input  logic [3:0]          rsvd_field,
  output logic [DST_BITS-1:0] dst_new,
  output logic                illegal
);
  logic                legal;
  logic [LANES-1:0]    lane_on;
  logic [DST_BITS-1:0] nxt;

  always_comb legal = (rsvd_field == RSVD_OK) && (vlen_sel != VL_BAD);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SRC_W-1:0] elem;
    logic [DST_W-1:0] cvt;

    assign lane_on[j] = (j < (2 << vlen_sel));
    assign elem = bcast ? src_vec[SRC_W-1:0] : src_vec[j*SRC_W +: SRC_W];

    u2d_lane_cvt #(
      .SRC_W(SRC_W), .EXP_W(EXP_W), .MANT_W(MANT_W), .BIAS(BIAS)
    ) cvt_i (.val(elem), .res(cvt));

    always_comb begin
      if (!lane_on[j])                  nxt[j*DST_W +: DST_W] = '0;
      else if (!mask_on || lane_mask[j]) nxt[j*DST_W +: DST_W] = cvt;
      else if (zero_mode)               nxt[j*DST_W +: DST_W] = '0;
      else                              nxt[j*DST_W +: DST_W] = dst_old[j*DST_W +: DST_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_new <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= !legal;
      dst_new <= legal ? nxt : dst_old;
    end
  end
endmodule

// File: rtl/u2d_vec_convert_chk.sv
module u2d_vec_convert_chk #(
  parameter int LANES = 8,
  localparam int DST_BITS = LANES * 64
) (
  input logic                clk,
  input logic                rst,
  input logic [DST_BITS-1:0] dst_old,
  input logic [LANES-1:0]    lane_mask,
  input logic                mask_on,
  input logic                zero_mode,
  input logic [1:0]          vlen_sel,
  input logic [3:0]          rsvd_field,
  input logic [DST_BITS-1:0] dst_new,
  input logic                illegal
);
  logic ok;
  assign ok = (rsvd_field == 4'b1111) && (vlen_sel != 2'b11);

  p_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !ok |=> illegal);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ok |=> dst_new == $past(dst_old));
  p_tail_r7: assert property (@(posedge clk) disable iff (rst)
    (ok && vlen_sel == 2'b00) |=> dst_new[DST_BITS-1:128] == '0);
  p_merge_r4: assert property (@(posedge clk) disable iff (rst)
    (ok && mask_on && !zero_mode && !lane_mask[0]) |=> dst_new[63:0] == $past(dst_old[63:0]));
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ok && mask_on && zero_mode && !lane_mask[0]) |=> dst_new[63:0] == 64'h0);
  p_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (ok && !mask_on) |=> !dst_new[63]);
  p_rst_r9: assert property (@(posedge clk)
    rst |=> (dst_new == '0 && !illegal));
endmodule

bind u2d_vec_convert u2d_vec_convert_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/u2d_vec_convert_tb_top.sv
`timescale 1ns/1ps
module u2d_vec_convert_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] src_vec = '0;
  logic [511:0] dst_old = '0;
  logic [7:0]   lane_mask = '0;
  logic         mask_on = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
  logic [1:0]   vlen_sel = 2'b10;
  logic [3:0]   rsvd_field = 4'hF;
  logic [511:0] dst_new;
  logic         illegal;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  u2d_vec_convert dut_i (.*);

  localparam int NV = 12;
  localparam logic [31:0] VALS [NV] = '{
    32'h0, 32'h1, 32'h2, 32'h3, 32'h8000_0000, 32'hFFFF_FFFF,
    32'h7FFF_FFFF, 32'h0001_0000, 32'h1234_5678, 32'hDEAD_BEEF,
    32'h0000_00FF, 32'h8000_0001};

  function automatic logic [63:0] ref_cvt(input logic [31:0] x);
    real r;
    r = longint'({32'b0, x});
    return $realtobits(r);
  endfunction

  function automatic logic [512:0] model();
    logic [511:0] d;
    int act;
    if (rsvd_field != 4'hF || vlen_sel == 2'b11) return {1'b1, dst_old};
    act = 2 << vlen_sel;
    d = '0;
    for (int j = 0; j < 8; j++) begin
      if (j < act) begin
        if (!mask_on || lane_mask[j])
          d[j*64 +: 64] = ref_cvt(bcast ? src_vec[31:0] : src_vec[j*32 +: 32]);
        else if (!zero_mode)
          d[j*64 +: 64] = dst_old[j*64 +: 64];
      end
    end
    return {1'b0, d};
  endfunction

  task automatic step(input string tag);
    logic [512:0] exp_v;
    exp_v = model();
    @(negedge clk);
    @(negedge clk);
    checks++;
    if ({illegal, dst_new} !== exp_v) begin
      failures++;
      $display("FAIL %s: got ill=%b dst=%h exp ill=%b dst=%h",
               tag, illegal, dst_new, exp_v[512], exp_v[511:0]);
    end
  endtask

  task automatic fill_old();
    for (int j = 0; j < 16; j++) dst_old[j*32 +: 32] = 32'hA5A5_0000 + 32'(j);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fill_old();
    repeat (3) @(negedge clk);
    checks++;
    if (dst_new !== '0 || illegal !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset: got ill=%b dst=%h exp 0", illegal, dst_new);
    end
    rst = 1'b0;

    // R2 / R1: table of values rotated across lanes
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 8; k++) src_vec[k*32 +: 32] = VALS[(i + k) % NV];
      step("R2 R1 table");
    end

    // R3 R4 R5 R7: all masks, both modes, all lengths
    for (int k = 0; k < 8; k++) src_vec[k*32 +: 32] = 32'h0100_0000 * 32'(k+1) + 32'(k);
    mask_on = 1'b1;
    for (int z = 0; z < 2; z++) begin
      zero_mode = z[0];
      for (int v = 0; v < 3; v++) begin
        vlen_sel = v[1:0];
        for (int m = 0; m < 256; m++) begin
          lane_mask = m[7:0];
          step(z ? "R5 R3 R7 zeroing" : "R4 R3 R7 merge");
        end
      end
    end

    // R3: masking off ignores lane_mask
    mask_on = 1'b0; lane_mask = 8'h00; zero_mode = 1'b1;
    for (int v = 0; v < 3; v++) begin vlen_sel = v[1:0]; step("R3 R1 R7 unmasked"); end

    // R6: broadcast
    bcast = 1'b1;
    src_vec[31:0] = 32'hFFFF_FFFF; step("R6 broadcast max");
    src_vec[31:0] = 32'h0;         step("R6 broadcast zero");
    mask_on = 1'b1; lane_mask = 8'hA5; zero_mode = 1'b0; vlen_sel = 2'b01;
    src_vec[31:0] = 32'h8000_0000; step("R6 broadcast masked");
    bcast = 1'b0; mask_on = 1'b0; vlen_sel = 2'b10;

    // R8: illegal encodings
    rsvd_field = 4'b0111; step("R8 reserved field");
    rsvd_field = 4'b0000; step("R8 reserved zero");
    rsvd_field = 4'hF; vlen_sel = 2'b11; step("R8 length code 11");
    vlen_sel = 2'b10; step("R8 legal again");

    // R9: synchronous reset mid-run
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    checks++;
    if (dst_new !== '0 || illegal !== 1'b0) begin
      failures++;
      $display("FAIL R9 mid reset: got ill=%b dst=%h exp 0", illegal, dst_new);
    end
    rst = 1'b0;
    step("R9 after reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule